// File: doc/BRIEF.md
# CPU Event Pulse Handshake Bridge

This block carries a wake-up event from an always-on controller running on the bus clock to one CPU running on its own free-running clock. Any number of enabled event sources are ORed upstream into one request. The bridge catches that request in a source-side hold flop, carries the held level across to the CPU clock, and turns each assertion of that level into exactly one CPU-clock pulse. The pulse is suitable for a CPU's receive-event input.

After the pulse, the CPU side raises a clear request. The clear request empties the source hold flop asynchronously. It stays high until the CPU side sees the carried level low, so the two sides finish a full handshake before the next event can be delivered. A request that arrives while a clear is in progress is remembered on the source side. It is released once the clear is over and produces a further pulse. Nothing is dropped and no pulses merge.

Top module: `cpu_evt_bridge`

## Requirements
- R1: While either active-low reset is low, and directly after both are released, `evt_pulse` and `evt_clr` are 0 and the source hold flop is empty. A reset applied in the middle of a handshake leaves no pulse pending afterwards.
- R2: A request of one bus-clock cycle produces exactly one `evt_pulse`, and that pulse is high for exactly one CPU-clock cycle.
- R3: A request held high for several bus-clock cycles produces only one pulse, provided it ends before `evt_clr` rises.
- R4: `evt_clr` rises in the CPU-clock cycle that directly follows the pulse.
- R5: `evt_clr` stays high until the synchronized source level has been seen low, and then falls. No pulse is produced while `evt_clr` is high.
- R6: A request that arrives while `evt_clr` is high, or during the bus-clock cycles in which its release is still being synchronized, is kept. After the clear completes, it produces exactly one additional pulse.
- R7: Requests separated by completed handshakes each produce their own pulse.
- R8: With no request, `evt_pulse` and `evt_clr` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Always-on controller clock (source domain) |
| bus_rst_n | input | 1 | Active-low asynchronous reset of the source domain |
| evt_req | input | 1 | ORed event request, synchronous to bus_clk, active high |
| cpu_clk | input | 1 | CPU free-running clock |
| cpu_rst_n | input | 1 | Active-low asynchronous reset of the CPU domain |
| evt_pulse | output | 1 | Single-cycle event pulse, synchronous to cpu_clk |
| evt_clr | output | 1 | Clear request back to the source hold flop, synchronous to cpu_clk |

## Verification
The assertions check the following on every clock:
- The pulse lasts one cycle.
- `evt_clr` follows each pulse directly.
- No pulse appears while `evt_clr` is high.
- `evt_clr` falls only once the synchronized level is low.
- The source hold flop stays empty while a clear is being absorbed.

Only the bench scenarios can show the end-to-end properties. These are that one request yields one pulse whatever its length, that a request landing inside a clear is replayed as a second pulse, and that a reset in the middle of a handshake leaves nothing behind.

// File: rtl/cpu_evt_bridge_pkg.sv
package cpu_evt_bridge_pkg;
   // Fewest flops allowed in any clock-crossing chain.
   localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/evb_sync_chain.sv
module evb_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/evb_src_hold.sv
module evb_src_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic clr_async,
   input  logic clr_seen,
   output logic held
);
   logic blk_q;
   logic redo_q;
   logic held_q;

   // Block window: opens on the clear edge, closes once the synced clear is low.
   always_ff @(posedge clk or negedge rst_n or posedge clr_async) begin
      if (!rst_n)         blk_q <= 1'b0;
      else if (clr_async) blk_q <= 1'b1;
      else if (!clr_seen) blk_q <= 1'b0;
   end

   // A request landing inside the block window is replayed afterwards.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               redo_q <= 1'b0;
      else if (blk_q && req)    redo_q <= 1'b1;
      else if (!blk_q)          redo_q <= 1'b0;
   end

   // Hold flop: set by a request, emptied asynchronously by the clear.
   always_ff @(posedge clk or negedge rst_n or posedge clr_async) begin
      if (!rst_n)                          held_q <= 1'b0;
      else if (clr_async)                  held_q <= 1'b0;
      else if (!blk_q && (req || redo_q))  held_q <= 1'b1;
   end

   assign held = held_q;

   AST_HOLD_EMPTY_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      blk_q |-> !held_q); // R6
endmodule

// File: rtl/evb_cpu_edge.sv
module evb_cpu_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pulse,
   output logic clr
);
   logic prev_q;
   logic pulse_q;
   logic clr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         pulse_q <= 1'b0;
         clr_q   <= 1'b0;
      end else begin
         prev_q  <= lvl;
         pulse_q <= lvl && !prev_q;
         clr_q   <= pulse_q || (clr_q && lvl);
      end
   end

   assign pulse = pulse_q;
   assign clr   = clr_q;

   AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q); // R2
   AST_CLR_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> clr_q); // R4
   AST_NO_PULSE_IN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q |-> !pulse_q); // R5
   AST_CLR_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clr_q) |-> !lvl); // R5
endmodule

// File: rtl/cpu_evt_bridge.sv
module cpu_evt_bridge #(
   parameter int unsigned CPU_SYNC_STAGES = 2,
   parameter int unsigned BUS_SYNC_STAGES = 2
) (
   input  logic bus_clk,
   input  logic bus_rst_n,
   input  logic evt_req,
   input  logic cpu_clk,
   input  logic cpu_rst_n,
   output logic evt_pulse,
   output logic evt_clr
);
   import cpu_evt_bridge_pkg::*;

   generate
      if (CPU_SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_cpu_sync
         $error("CPU_SYNC_STAGES below minimum");
      end
      if (BUS_SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_bus_sync
         $error("BUS_SYNC_STAGES below minimum");
      end
   endgenerate

   logic held;
   logic held_cpu;
   logic clr_bus;
   logic clr_int;

   evb_src_hold u_src (
      .clk       (bus_clk),
      .rst_n     (bus_rst_n),
      .req       (evt_req),
      .clr_async (clr_int),
      .clr_seen  (clr_bus),
      .held      (held)
   );

   evb_sync_chain #(.STAGES(CPU_SYNC_STAGES)) u_to_cpu (
      .clk   (cpu_clk),
      .rst_n (cpu_rst_n),
      .d     (held),
      .q     (held_cpu)
   );

   evb_sync_chain #(.STAGES(BUS_SYNC_STAGES)) u_to_bus (
      .clk   (bus_clk),
      .rst_n (bus_rst_n),
      .d     (clr_int),
      .q     (clr_bus)
   );

   evb_cpu_edge u_edge (
      .clk   (cpu_clk),
      .rst_n (cpu_rst_n),
      .lvl   (held_cpu),
      .pulse (evt_pulse),
      .clr   (clr_int)
   );

   assign evt_clr = clr_int;
endmodule

// File: tb/cpu_evt_bridge_tb.sv
module cpu_evt_bridge_tb;
   logic bus_clk = 1'b0;
   logic cpu_clk = 1'b0;
   logic rst_n   = 1'b0;
   logic evt_req = 1'b0;
   logic evt_pulse;
   logic evt_clr;

   int n_checks = 0;
   int n_fail   = 0;
   int pulse_cnt = 0;
   int wide_cnt  = 0;
   int bad_r4    = 0;
   int bad_r5    = 0;
   bit saw_clr   = 0;
   bit pulse_prev = 0;
   bit clr_prev   = 0;
   bit finished   = 0;

   cpu_evt_bridge u_dut (
      .bus_clk   (bus_clk),
      .bus_rst_n (rst_n),
      .evt_req   (evt_req),
      .cpu_clk   (cpu_clk),
      .cpu_rst_n (rst_n),
      .evt_pulse (evt_pulse),
      .evt_clr   (evt_clr)
   );

   always #10 cpu_clk = ~cpu_clk;
   initial begin
      #3;
      forever #7 bus_clk = ~bus_clk;
   end

   always @(negedge cpu_clk) begin
      if (!rst_n) begin
         pulse_prev = 0;
         clr_prev   = 0;
      end else begin
         if (evt_pulse) pulse_cnt++;
         if (evt_pulse && pulse_prev) wide_cnt++;
         if (evt_clr && !clr_prev && !pulse_prev) bad_r4++;
         if (evt_clr && evt_pulse) bad_r5++;
         if (evt_clr) saw_clr = 1;
         pulse_prev = evt_pulse;
         clr_prev   = evt_clr;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic strobe(input int cycles);
      @(negedge bus_clk);
      evt_req = 1'b1;
      repeat (cycles) @(negedge bus_clk);
      evt_req = 1'b0;
   endtask

   task automatic settle();
      repeat (40) @(negedge cpu_clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge cpu_clk);
      chk(evt_pulse == 1'b0, "R1 pulse in reset", evt_pulse, 0);
      chk(evt_clr == 1'b0, "R1 clr in reset", evt_clr, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge cpu_clk);
      chk(evt_pulse == 1'b0 && evt_clr == 1'b0, "R1 after release", {evt_pulse, evt_clr}, 0);
   endtask

   task automatic t_idle();
      int c0 = pulse_cnt;
      bit clr_seen_idle = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge cpu_clk);
         if (evt_clr) clr_seen_idle = 1;
      end
      chk(pulse_cnt == c0, "R8 idle pulses", pulse_cnt - c0, 0);
      chk(!clr_seen_idle, "R8 idle clr", clr_seen_idle, 0);
   endtask

   task automatic t_single();
      int c0 = pulse_cnt;
      saw_clr = 0;
      strobe(1);
      settle();
      chk(pulse_cnt - c0 == 1, "R2 one pulse per strobe", pulse_cnt - c0, 1);
      chk(wide_cnt == 0, "R2 pulse width", wide_cnt, 0);
      chk(bad_r4 == 0, "R4 clr follows pulse", bad_r4, 0);
      chk(saw_clr, "R5 clr raised", saw_clr, 1);
      chk(evt_clr == 1'b0, "R5 clr released", evt_clr, 0);
      chk(bad_r5 == 0, "R5 no pulse during clr", bad_r5, 0);
   endtask

   task automatic t_long();
      int c0 = pulse_cnt;
      strobe(3);
      settle();
      chk(pulse_cnt - c0 == 1, "R3 long strobe one pulse", pulse_cnt - c0, 1);
   endtask

   task automatic t_during_clr();
      int c0 = pulse_cnt;
      int guard = 0;
      strobe(1);
      while (!evt_clr && guard < 100) begin
         @(negedge bus_clk);
         guard++;
      end
      evt_req = 1'b1;
      @(negedge bus_clk);
      evt_req = 1'b0;
      settle();
      settle();
      chk(pulse_cnt - c0 == 2, "R6 request during clear replayed", pulse_cnt - c0, 2);
      chk(evt_clr == 1'b0, "R6 handshake closed", evt_clr, 0);
   endtask

   task automatic t_series();
      int c0 = pulse_cnt;
      for (int k = 0; k < 3; k++) begin
         strobe(1);
         settle();
      end
      chk(pulse_cnt - c0 == 3, "R7 separate strobes", pulse_cnt - c0, 3);
   endtask

   task automatic t_mid_reset();
      int c0;
      int guard = 0;
      strobe(1);
      while (!evt_clr && guard < 100) begin
         @(negedge cpu_clk);
         guard++;
      end
      rst_n = 1'b0;
      @(negedge cpu_clk);
      chk(evt_pulse == 1'b0 && evt_clr == 1'b0, "R1 mid-handshake reset", {evt_pulse, evt_clr}, 0);
      rst_n = 1'b1;
      c0 = pulse_cnt;
      settle();
      chk(pulse_cnt == c0, "R1 nothing pending after reset", pulse_cnt - c0, 0);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_single();
      t_long();
      t_during_clr();
      t_series();
      t_mid_reset();
      chk(wide_cnt == 0 && bad_r5 == 0, "R2 R5 whole run", wide_cnt + bad_r5, 0);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge cpu_clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule